// File: doc/BRIEF.md
# Software-Managed Direct-Mapped Address Translator

This block turns a 32-bit virtual address into a 32-bit physical address for a processor that uses fixed 4 kB pages. It keeps two translation tables that work on their own: one for instruction fetches and one for data accesses. Each table is direct-mapped. The ten virtual-page-number bits just above the page offset pick one entry. The ten bits above those must then match the tag stored in that entry. Each entry also holds a 20-bit physical page number, a write-protect flag and a valid flag.

No hardware walks the page tables. When a lookup finds no matching entry, the block raises a miss exception, and software writes the entry through a register-style fill port. The same port can also start a sweep that invalidates a whole table. A store to a write-protected page raises a protection fault, while a load from that page is granted. When translation is switched off, addresses pass through untouched. Every lookup gives one registered response in the cycle after the request.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `rsp_pa` is the stored physical page number placed in bits [31:12], with `lk_va[11:0]` copied unchanged into bits [11:0]. For example, data entry 1 holding tag 0x280, page 0xB0001, protect 1 and valid 1 maps load address 0xA0001004 to 0xB0001004.
- R2: The entry index is `lk_va[21:12]` and the compared tag is `lk_va[31:22]`. A lookup hits only when the indexed entry is valid and its tag is equal. Otherwise `rsp_miss`=1, `rsp_grant`=0 and `rsp_pa`=0.
- R3: `lk_instr`=1 consults the instruction table and `lk_instr`=0 consults the data table. `wr_sel` and `inv_sel` use the same coding: 1 means instruction, 0 means data. An entry written into one table has no effect on lookups in the other.
- R4: A store (`lk_store`=1) that hits an entry whose protect bit is 1 gives `rsp_fault`=1 and `rsp_grant`=0, and `rsp_pa` still carries the translated address. A load that hits the same entry is granted. A store to an entry whose protect bit is 0 is also granted.
- R5: A fill write sampled on a clock edge first affects lookups sampled on the following edge. A lookup sampled on the same edge as the write sees the old contents.
- R6: An invalidate request clears every valid bit of the selected table. The sweep clears CLR_LANES entries per cycle and ends within 1024/CLR_LANES cycles after the request edge, which is 32 cycles by default. The other table is not affected. After the sweep, fills work as usual.
- R7: While a table's sweep runs, lookups in that table report a miss. Fill writes aimed at that table are ignored, and they leave no valid entry behind once the sweep ends.
- R8: When `xlate_en`=0, `rsp_pa` equals `lk_va`, `rsp_grant`=1, and `rsp_miss` and `rsp_fault` stay 0, whatever the tables hold.
- R9: Each lookup sampled with `lk_valid`=1 gives exactly one response, with `rsp_valid`=1 on the next cycle. With no request, `rsp_valid`, `rsp_grant`, `rsp_miss` and `rsp_fault` are all 0.
- R10: A miss takes priority over a protection fault, so `rsp_miss` and `rsp_fault` are never 1 together.
- R11: Synchronous active-high reset invalidates every entry of both tables and clears the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 for a store, 0 for a load or fetch |
| lk_instr | input | 1 | 1 selects the instruction table, 0 the data table |
| xlate_en | input | 1 | Translation enable; 0 passes addresses through |
| wr_en | input | 1 | Fill write strobe |
| wr_sel | input | 1 | Table to fill: 1 instruction, 0 data |
| wr_index | input | 10 | Entry index to fill |
| wr_tag | input | 10 | Tag to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_ro | input | 1 | Write-protect bit to store |
| wr_valid | input | 1 | Valid bit to store |
| inv_req | input | 1 | Start invalidating a whole table |
| inv_sel | input | 1 | Table to invalidate: 1 instruction, 0 data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 32 | Physical address |
| rsp_grant | output | 1 | Access granted |
| rsp_miss | output | 1 | Miss exception |
| rsp_fault | output | 1 | Protection-fault exception |

## Verification
If a stored tag, page number or protect bit is corrupted, the result appears on the very next lookup to that index: a wrong `rsp_pa`, a false miss, or a wrong grant or fault, one cycle after the request. A valid bit that is stuck, or a sweep that skips lanes or stops early, appears as a hit after the sweep on an entry that should be empty. A sweep that ignores its busy state appears as a fill that survives the sweep. The bench keeps its own model of both tables and compares every response against that model in order, so a table mixup shows up as a hit or miss in the wrong table at the first cross-table lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int IDX_BITS  = 10;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int TAG_W     = VPN_W - IDX_BITS;
    localparam int PPN_W     = VPN_W;
    localparam int DEPTH     = 1 << IDX_BITS;
    localparam int N_TABLES  = 2;

    typedef enum logic {
        TBL_DATA  = 1'b0,
        TBL_INSTR = 1'b1
    } tbl_sel_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic             ro;
    } tlb_entry_t;

    typedef struct packed {
        logic            vld;
        logic [VA_W-1:0] pa;
        logic            grant;
        logic            miss;
        logic            fault;
    } tlb_rsp_t;

    function automatic logic [IDX_BITS-1:0] va_index(input logic [VA_W-1:0] va);
        return va[PAGE_BITS +: IDX_BITS];
    endfunction

    function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
        return va[PAGE_BITS+IDX_BITS +: TAG_W];
    endfunction

    function automatic logic [PAGE_BITS-1:0] va_offset(input logic [VA_W-1:0] va);
        return va[PAGE_BITS-1:0];
    endfunction

endpackage

// File: rtl/tlb_table.sv
module tlb_table
    import tlb_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  tlb_entry_t          wr_entry,
    input  logic                wr_vld,
    input  logic                inv_req,
    input  logic [IDX_BITS-1:0] rd_idx,
    output tlb_entry_t          rd_entry,
    output logic                rd_vld
);
    localparam int CHUNKS = DEPTH / LANES;
    localparam int CW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;

    tlb_entry_t       mem [DEPTH];
    logic [DEPTH-1:0] vbits;
    logic             busy_q;
    logic [CW-1:0]    ptr_q;

    // Entry payload: no reset needed, validity lives in vbits.
    always_ff @(posedge clk) begin
        if (wr_en && !busy_q) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    // Sweep sequencer.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (!busy_q) begin
            if (inv_req) begin
                busy_q <= 1'b1;
                ptr_q  <= '0;
            end
        end else begin
            if (ptr_q == CW'(CHUNKS - 1)) begin
                busy_q <= 1'b0;
            end
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Valid bits: cleared by reset and by the sweep, set by fills when idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            vbits <= '0;
        end else if (busy_q) begin
            vbits[int'(ptr_q)*LANES +: LANES] <= '0;
        end else if (wr_en) begin
            vbits[wr_idx] <= wr_vld;
        end
    end

    assign rd_entry = mem[rd_idx];
    assign rd_vld   = vbits[rd_idx] & ~busy_q;

endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_va,
    input  logic            lk_store,
    input  logic            xlate_en,
    input  tlb_entry_t      ent,
    input  logic            ent_vld,
    output tlb_rsp_t        rsp
);
    logic     hit;
    tlb_rsp_t nxt;

    always_comb begin
        hit       = ent_vld && (ent.tag == va_tag(lk_va));
        nxt.vld   = 1'b1;
        if (!xlate_en) begin
            nxt.pa    = lk_va;
            nxt.miss  = 1'b0;
            nxt.fault = 1'b0;
        end else if (!hit) begin
            nxt.pa    = '0;
            nxt.miss  = 1'b1;
            nxt.fault = 1'b0;
        end else begin
            nxt.pa    = {ent.ppn, va_offset(lk_va)};
            nxt.miss  = 1'b0;
            nxt.fault = lk_store && ent.ro;
        end
        nxt.grant = !nxt.miss && !nxt.fault;
    end

    always_ff @(posedge clk) begin
        if (rst || !lk_valid) begin
            rsp <= '0;
        end else begin
            rsp <= nxt;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int CLR_LANES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_va,
    input  logic                lk_store,
    input  logic                lk_instr,
    input  logic                xlate_en,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [IDX_BITS-1:0] wr_index,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic                wr_ro,
    input  logic                wr_valid,
    input  logic                inv_req,
    input  logic                inv_sel,
    output logic                rsp_valid,
    output logic [VA_W-1:0]     rsp_pa,
    output logic                rsp_grant,
    output logic                rsp_miss,
    output logic                rsp_fault
);
    tlb_entry_t          wr_entry;
    logic [IDX_BITS-1:0] rd_idx;
    tlb_entry_t          tbl_ent [N_TABLES];
    logic                tbl_vld [N_TABLES];
    tlb_entry_t          sel_ent;
    logic                sel_vld;
    tlb_rsp_t            rsp;

    assign wr_entry = '{tag: wr_tag, ppn: wr_ppn, ro: wr_ro};
    assign rd_idx   = va_index(lk_va);

    for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
        tlb_table #(.LANES(CLR_LANES)) u_table (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_sel == 1'(t))),
            .wr_idx   (wr_index),
            .wr_entry (wr_entry),
            .wr_vld   (wr_valid),
            .inv_req  (inv_req && (inv_sel == 1'(t))),
            .rd_idx   (rd_idx),
            .rd_entry (tbl_ent[t]),
            .rd_vld   (tbl_vld[t])
        );
    end

    always_comb begin
        if (tbl_sel_e'(lk_instr) == TBL_INSTR) begin
            sel_ent = tbl_ent[TBL_INSTR];
            sel_vld = tbl_vld[TBL_INSTR];
        end else begin
            sel_ent = tbl_ent[TBL_DATA];
            sel_vld = tbl_vld[TBL_DATA];
        end
    end

    tlb_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_va    (lk_va),
        .lk_store (lk_store),
        .xlate_en (xlate_en),
        .ent      (sel_ent),
        .ent_vld  (sel_vld),
        .rsp      (rsp)
    );

    assign rsp_valid = rsp.vld;
    assign rsp_pa    = rsp.pa;
    assign rsp_grant = rsp.grant;
    assign rsp_miss  = rsp.miss;
    assign rsp_fault = rsp.fault;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_va,
    input logic            xlate_en,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_pa,
    input logic            rsp_grant,
    input logic            rsp_miss,
    input logic            rsp_fault
);
    a_r10_miss_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(rsp_miss && rsp_fault));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_grant && !rsp_miss && !rsp_fault));

    a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !xlate_en) |=> (rsp_pa == $past(lk_va) && rsp_grant && !rsp_miss && !rsp_fault));

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && xlate_en) |=> (rsp_miss || rsp_pa[PAGE_BITS-1:0] == $past(lk_va[PAGE_BITS-1:0])));

    a_r2_miss_denied: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (!rsp_grant && rsp_pa == '0));

    a_r4_fault_denied: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !rsp_grant);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_va     (lk_va),
    .xlate_en  (xlate_en),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_grant (rsp_grant),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
    import tlb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_store = 0, lk_instr = 0, xlate_en = 1;
    logic [31:0] lk_va = '0;
    logic        wr_en = 0, wr_sel = 0, wr_ro = 0, wr_valid = 0;
    logic [9:0]  wr_index = '0, wr_tag = '0;
    logic [19:0] wr_ppn = '0;
    logic        inv_req = 0, inv_sel = 0;
    logic        rsp_valid, rsp_grant, rsp_miss, rsp_fault;
    logic [31:0] rsp_pa;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_store(lk_store),
        .lk_instr(lk_instr), .xlate_en(xlate_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_index(wr_index), .wr_tag(wr_tag), .wr_ppn(wr_ppn), .wr_ro(wr_ro),
        .wr_valid(wr_valid), .inv_req(inv_req), .inv_sel(inv_sel),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_grant(rsp_grant),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault)
    );

    typedef struct {
        logic [34:0] val;   // {pa, grant, miss, fault}
        string       req;
    } exp_t;
    exp_t q[$];

    // Reference model of both tables, index 0 = data, 1 = instruction.
    logic        mv [2][1024];
    logic [9:0]  mt [2][1024];
    logic [19:0] mp [2][1024];
    logic        mr [2][1024];

    function automatic logic [31:0] mkva(input logic [9:0] tag, input logic [9:0] idx,
                                         input logic [11:0] off);
        return {tag, idx, off};
    endfunction

    function automatic logic [34:0] predict(input logic [31:0] va, input logic st,
                                            input logic ins, input logic en,
                                            input logic force_miss);
        int   t = ins ? 1 : 0;
        int   i = int'(va[21:12]);
        logic hit, ms, ft;
        logic [31:0] pa;
        if (!en) return {va, 1'b1, 1'b0, 1'b0};
        hit = !force_miss && mv[t][i] && (mt[t][i] == va[31:22]);
        ms  = !hit;
        ft  = hit && st && mr[t][i];
        pa  = ms ? 32'h0 : {mp[t][i], va[11:0]};
        return {pa, !ms && !ft, ms, ft};
    endfunction

    task automatic check(input bit ok, input string req, input logic [34:0] act,
                         input logic [34:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic st, input logic ins,
                             input logic en, input string req, input logic force_miss = 1'b0);
        exp_t e;
        @(negedge clk);
        lk_valid = 1; lk_va = va; lk_store = st; lk_instr = ins; xlate_en = en;
        e.val = predict(va, st, ins, en, force_miss);
        e.req = req;
        q.push_back(e);
        @(posedge clk);
        #1 lk_valid = 0;
    endtask

    task automatic drive_write(input logic sel, input logic [9:0] idx, input logic [9:0] tag,
                               input logic [19:0] ppn, input logic ro, input logic v);
        wr_en = 1; wr_sel = sel; wr_index = idx; wr_tag = tag; wr_ppn = ppn;
        wr_ro = ro; wr_valid = v;
    endtask

    task automatic model_write(input logic sel, input logic [9:0] idx, input logic [9:0] tag,
                               input logic [19:0] ppn, input logic ro, input logic v);
        int t = sel ? 1 : 0;
        mv[t][idx] = v; mt[t][idx] = tag; mp[t][idx] = ppn; mr[t][idx] = ro;
    endtask

    task automatic do_write(input logic sel, input logic [9:0] idx, input logic [9:0] tag,
                            input logic [19:0] ppn, input logic ro, input logic v,
                            input bit upd = 1'b1);
        @(negedge clk);
        drive_write(sel, idx, tag, ppn, ro, v);
        @(posedge clk);
        #1 wr_en = 0;
        if (upd) model_write(sel, idx, tag, ppn, ro, v);
    endtask

    // R5: write and lookup sampled on the same edge; expectation uses old contents.
    task automatic write_and_lookup(input logic sel, input logic [9:0] idx, input logic [9:0] tag,
                                    input logic [19:0] ppn, input logic ro,
                                    input logic [31:0] va, input logic st);
        exp_t e;
        @(negedge clk);
        drive_write(sel, idx, tag, ppn, ro, 1'b1);
        lk_valid = 1; lk_va = va; lk_store = st; lk_instr = sel; xlate_en = 1;
        e.val = predict(va, st, sel, 1'b1, 1'b0);
        e.req = "R5 same-edge sees old entry";
        q.push_back(e);
        @(posedge clk);
        #1 begin wr_en = 0; lk_valid = 0; end
        model_write(sel, idx, tag, ppn, ro, 1'b1);
    endtask

    task automatic do_inv(input logic sel);
        @(negedge clk);
        inv_req = 1; inv_sel = sel;
        @(posedge clk);
        #1 inv_req = 0;
        for (int i = 0; i < 1024; i++) mv[sel ? 1 : 0][i] = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            logic [34:0] act;
            act = {rsp_pa, rsp_grant, rsp_miss, rsp_fault};
            if (q.size() == 0) begin
                check(1'b0, "R9 response without request", act, 35'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(act === e.val, e.req, act, e.val);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 1024; i++) begin
                mv[t][i] = 0; mt[t][i] = 0; mp[t][i] = 0; mr[t][i] = 0;
            end

        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(!rsp_valid && !rsp_grant && !rsp_miss && !rsp_fault, "R11 reset outputs",
              {rsp_pa, rsp_grant, rsp_miss, rsp_fault}, 35'h0);

        do_lookup(32'hA0001004, 0, 0, 1, "R11 empty after reset");
        do_lookup(32'hA0001004, 0, 1, 1, "R11 instr empty after reset");

        // Worked example in the data table.
        do_write(0, 10'd1, 10'h280, 20'hB0001, 1, 1);
        do_lookup(32'hA0001004, 0, 0, 1, "R1 load translates 0xA0001004");
        do_lookup(32'hA0001FFC, 0, 0, 1, "R1 offset passthrough");
        do_lookup(32'hA0001004, 1, 0, 1, "R4 store to protected page faults");
        do_lookup(32'hA0001004, 0, 1, 1, "R3 instr table does not see data entry");
        do_lookup(32'hA0401004, 1, 0, 1, "R2 R10 tag mismatch store misses only");

        // Instruction table entry.
        do_write(1, 10'h155, 10'h3FF, 20'h12345, 0, 1);
        do_lookup(mkva(10'h3FF, 10'h155, 12'h0AB), 0, 1, 1, "R3 instr hit");
        do_lookup(mkva(10'h3FF, 10'h155, 12'h0AB), 0, 0, 1, "R3 data misses instr entry");

        // Unprotected data page store.
        do_write(0, 10'd7, 10'h011, 20'h0F00D, 0, 1);
        do_lookup(mkva(10'h011, 10'd7, 12'h800), 1, 0, 1, "R4 store to writable page");
        // Entry written with valid 0.
        do_write(0, 10'd9, 10'h022, 20'h00009, 0, 0);
        do_lookup(mkva(10'h022, 10'd9, 12'h004), 0, 0, 1, "R2 invalid entry misses");

        // Same-edge write visibility.
        write_and_lookup(0, 10'd1, 10'h280, 20'h0ABCD, 0, 32'hA0001004, 1);
        do_lookup(32'hA0001004, 1, 0, 1, "R5 new entry visible next cycle");

        // Translation disabled.
        do_lookup(32'hA0001004, 1, 0, 0, "R8 bypass mapped address");
        do_lookup(32'h12345678, 1, 1, 0, "R8 bypass unmapped address");

        // Back-to-back lookups.
        do_lookup(mkva(10'h011, 10'd7, 12'h123), 0, 0, 1, "R9 back-to-back a");
        do_lookup(mkva(10'h3FF, 10'h155, 12'h456), 1, 1, 1, "R9 back-to-back b");

        // Invalidate the data table.
        do_inv(0);
        do_lookup(32'hA0001004, 0, 0, 1, "R7 lookup during sweep misses", 1'b1);
        do_write(0, 10'd7, 10'h033, 20'h00777, 0, 1, 1'b0);
        do_lookup(mkva(10'h3FF, 10'h155, 12'h010), 0, 1, 1, "R6 other table unaffected during sweep");
        repeat (36) @(posedge clk);
        do_lookup(32'hA0001004, 0, 0, 1, "R6 entry cleared after sweep");
        do_lookup(mkva(10'h011, 10'd7, 12'h000), 0, 0, 1, "R6 second entry cleared");
        do_lookup(mkva(10'h033, 10'd7, 12'h000), 0, 0, 1, "R7 fill during sweep ignored");
        do_lookup(mkva(10'h3FF, 10'h155, 12'h020), 0, 1, 1, "R6 instr table intact after sweep");
        do_write(0, 10'd1, 10'h280, 20'hB0001, 1, 1);
        do_lookup(32'hA0001004, 0, 0, 1, "R6 fill works after sweep");

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R9 every request answered", 35'(q.size()), 35'h0);
        finish_run();
    end

endmodule